// File: doc/BRIEF.md
# Double-Buffered Frequency Control Register File

This block is the control front end of a numerically controlled oscillator. A processor writes bytes over an 8-bit, write-only port that has a 4-bit address, a write strobe and an active-low write enable. Each write lands in a shadow ("master") byte register. The oscillator reads only a second ("slave") copy, so a multi-byte frequency word can be built up over several writes and then handed over in one step.

The handover, called a commit, happens in two ways. A write of any data to the top address (15) commits. Holding the active-low update input low also commits, after that input has passed through a two-flop synchronizer, and it keeps committing on every cycle while it stays low. The write strobe is sampled in the synthesis clock domain and only its rising edge counts, so the port accepts at most one write every two clock cycles. Reset loads known defaults, including a center word of one quarter of the clock rate.

Top module: `dds_ctl_regfile`

## Requirements
- R1: During and after synchronous reset the outputs hold the defaults: center word 0x4000_0000_0000, offset word 0, serial options 0x00, enable byte 0xC0 (center on at bit 7, serial on at bit 6, offset off at bit 5), config byte 0x00.
- R2: A write is taken when the strobe rises while the write enable is low. Addresses 0–5 hold the center word and 6–11 hold the offset word, least significant byte first. Address 12 holds serial options, 13 the enable byte and 14 the config byte.
- R3: A write to addresses 0–14 changes no output until a commit takes place.
- R4: A write of any data to address 15 copies every master byte to the outputs, and the new values are visible after the capturing edge.
- R5: Once the update input is low at a clock edge, the outputs take the master contents on the third edge. While the update input stays low, a master write appears at the outputs one cycle after it is captured.
- R6: A strobe edge with the write enable high writes nothing.
- R7: A strobe held high over several clock edges produces exactly one write, using the data present at its first edge.
- R8: A write presented at the first clock edge after reset is released is ignored.
- R9: Back-to-back writes with one idle cycle between them are all stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Synthesis clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Write strobe; its rising edge captures a byte |
| wr_en_n | input | 1 | Active-low write enable |
| wr_addr | input | 4 | Register address; 15 commits |
| wr_data | input | 8 | Write data byte |
| update_n | input | 1 | Active-low commit request, synchronized inside |
| center_word | output | 48 | Committed center frequency word |
| offset_word | output | 48 | Committed offset frequency word |
| serial_opts | output | 8 | Committed serial options byte |
| enable_ctl | output | 8 | Committed enables: bit 7 center, bit 6 serial, bit 5 offset |
| test_cfg | output | 8 | Committed config byte |

## Verification
A table of frequency pairs is written byte by byte and committed through address 15. The pairs use distinct byte values in every lane and include all-ones and alternating patterns, so a swapped byte lane or a swapped word shows up. After the last data byte and before the commit, the outputs are compared against the previous pair, which separates master storage from slave storage. Directed cases follow. The update pin is sampled cycle by cycle to pin down the synchronizer latency and the follow-while-low behaviour. Other cases cover a disabled write, a strobe held high with data changing under it, a write at the first edge after reset, and the reset defaults.

// File: rtl/dds_ctl_pkg.sv
// Package: shared sizes and reset defaults for the frequency control register file.
// Assumes byte-wide registers, two frequency words and three control bytes.
package dds_ctl_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int FREQ_W   = 48;
    localparam int WORD_B   = FREQ_W / BYTE_W;
    localparam int NREG     = 2 * WORD_B + 3;
    localparam int OPT_IDX  = 2 * WORD_B;
    localparam int ENA_IDX  = 2 * WORD_B + 1;
    localparam int CFG_IDX  = 2 * WORD_B + 2;
    localparam int FLAT_W   = NREG * BYTE_W;

    // Default value of one register byte after reset.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        if (idx == WORD_B - 1)
            return BYTE_W'(8'h40);
        else if (idx == ENA_IDX)
            return BYTE_W'(8'hC0);
        else
            return '0;
    endfunction

    // Defaults of the whole bank packed into one vector.
    function automatic logic [FLAT_W-1:0] flat_default();
        logic [FLAT_W-1:0] v;
        v = '0;
        for (int i = 0; i < NREG; i++)
            v[i*BYTE_W +: BYTE_W] = reg_default(i);
        return v;
    endfunction
endpackage

// File: rtl/dds_wr_capture.sv
// Write capture: turns a rising edge on the write strobe, qualified by the
// active-low enable, into a one-cycle write pulse in the clk domain.
// Assumes the strobe is synchronous to clk and toggles no faster than clk/2.
// The first edge after reset release is refused.
module dds_wr_capture #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          wr_en_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_go,
    output logic [AW-1:0] wr_a,
    output logic [DW-1:0] wr_d
);
    logic stb_q;
    logic rdy;

    // Remember the strobe level and open the port one edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            rdy   <= 1'b0;
        end else begin
            stb_q <= wr_stb;
            rdy   <= 1'b1;
        end
    end

    assign wr_go = wr_stb & ~stb_q & ~wr_en_n & rdy;
    assign wr_a  = wr_addr;
    assign wr_d  = wr_data;

    // R7: a held strobe never yields two pulses in a row
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);
endmodule

// File: rtl/dds_upd_sync.sv
// Update synchronizer: two flops harden the asynchronous active-low update
// pin against metastability. upd_on is high while the synchronized pin is low.
module dds_upd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic update_n,
    output logic upd_on
);
    logic s1;
    logic s2;

    // Shift the pin level through two stages; reset to the idle (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= update_n;
            s2 <= s1;
        end
    end

    assign upd_on = ~s2;
endmodule

// File: rtl/dds_master_bank.sv
// Master bank: NREG byte registers written by the capture pulse, each loaded
// with its own default at reset. The contents are presented as one flat vector.
module dds_master_bank
    import dds_ctl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W,
    parameter int NR = NREG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_go,
    input  logic [AW-1:0]  wr_a,
    input  logic [DW-1:0]  wr_d,
    output logic [NR*DW-1:0] m_flat
);
    for (genvar g = 0; g < NR; g++) begin : g_byte
        logic [DW-1:0] m;

        // Load this byte when the write pulse addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                m <= DW'(reg_default(g));
            else if (wr_go && wr_a == AW'(g))
                m <= wr_d;
        end

        assign m_flat[g*DW +: DW] = m;

        // R2: an addressed write lands in exactly this byte
        a_r2_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && wr_a == AW'(g)) |=> m_flat[g*DW +: DW] == $past(wr_d));
    end
endmodule

// File: rtl/dds_ctl_regfile.sv
// Top: double-buffered control register file. Writes fill the master bank.
// A commit (address 15 written, or the synchronized update pin low) copies
// the whole bank to the slave copy that drives the outputs.
// Assumes the write strobe is synchronous to clk at no more than clk/2.
module dds_ctl_regfile
    import dds_ctl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W,
    parameter int FW = FREQ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          wr_en_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          update_n,
    output logic [FW-1:0] center_word,
    output logic [FW-1:0] offset_word,
    output logic [DW-1:0] serial_opts,
    output logic [DW-1:0] enable_ctl,
    output logic [DW-1:0] test_cfg
);
    localparam int NR       = NREG;
    localparam int TOT_W    = NR * DW;
    localparam int COMMIT_A = (1 << AW) - 1;

    logic             wr_go;
    logic [AW-1:0]    wr_a;
    logic [DW-1:0]    wr_d;
    logic             upd_on;
    logic             commit;
    logic [TOT_W-1:0] m_flat;
    logic [TOT_W-1:0] s_flat;

    dds_wr_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_en_n(wr_en_n),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_go(wr_go), .wr_a(wr_a), .wr_d(wr_d)
    );

    dds_upd_sync u_sync (
        .clk(clk), .rst_n(rst_n), .update_n(update_n), .upd_on(upd_on)
    );

    dds_master_bank #(.AW(AW), .DW(DW), .NR(NR)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_a(wr_a),
        .wr_d(wr_d), .m_flat(m_flat)
    );

    assign commit = upd_on | (wr_go && wr_a == AW'(COMMIT_A));

    // Slave copy: take the whole master bank in one edge on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_flat <= TOT_W'(flat_default());
        else if (commit)
            s_flat <= m_flat;
    end

    assign center_word = s_flat[0 +: FW];
    assign offset_word = s_flat[FW +: FW];
    assign serial_opts = s_flat[OPT_IDX*DW +: DW];
    assign enable_ctl  = s_flat[ENA_IDX*DW +: DW];
    assign test_cfg    = s_flat[CFG_IDX*DW +: DW];

    // R3: without a commit the slave copy does not move
    a_r3_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(s_flat));

    // R4: a commit copies the master bank as it stood at the edge
    a_r4_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> s_flat == $past(m_flat));
endmodule

// File: tb/sim_dds_ctl_regfile.sv
module sim_dds_ctl_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic        wr_en_n = 1'b1;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        update_n = 1'b1;
    logic [47:0] center_word, offset_word;
    logic [7:0]  serial_opts, enable_ctl, test_cfg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dds_ctl_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_en_n(wr_en_n),
        .wr_addr(wr_addr), .wr_data(wr_data), .update_n(update_n),
        .center_word(center_word), .offset_word(offset_word),
        .serial_opts(serial_opts), .enable_ctl(enable_ctl), .test_cfg(test_cfg)
    );

    // {center, offset} pairs
    localparam logic [95:0] VEC [4] = '{
        {48'h0123_4567_89AB, 48'hFEDC_BA98_7654},
        {48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001},
        {48'hA5A5_5A5A_C33C, 48'h8000_0000_0000},
        {48'h1122_3344_5566, 48'h7788_99AA_BBCC}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write: strobe high for one cycle, low for one (half clock rate).
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en_n = 1'b0; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; wr_en_n = 1'b1;
    endtask

    task automatic wr_word(input int base, input logic [47:0] w);
        for (int b = 0; b < 6; b++)
            wr(4'(base + b), w[b*8 +: 8]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] pc, po;
        repeat (3) @(negedge clk);
        // R1 defaults while in reset
        chk("R1 center", 64'(center_word), 64'h4000_0000_0000);
        chk("R1 enable", 64'(enable_ctl), 64'hC0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 offset", 64'(offset_word), 64'h0);
        chk("R1 opts", 64'(serial_opts), 64'h0);
        chk("R1 cfg", 64'(test_cfg), 64'h0);

        // Table walk: R2, R3, R4, R9
        pc = 48'h4000_0000_0000; po = '0;
        for (int i = 0; i < 4; i++) begin
            wr_word(0, VEC[i][95:48]);
            wr_word(6, VEC[i][47:0]);
            chk("R3 center held", 64'(center_word), 64'(pc));
            chk("R3 offset held", 64'(offset_word), 64'(po));
            wr(4'd15, 8'(i * 37));
            chk("R4/R9 center", 64'(center_word), 64'(VEC[i][95:48]));
            chk("R4/R2 offset", 64'(offset_word), 64'(VEC[i][47:0]));
            pc = VEC[i][95:48]; po = VEC[i][47:0];
        end

        // R2 control bytes
        wr(4'd12, 8'h5A); wr(4'd13, 8'h20); wr(4'd14, 8'h30);
        chk("R3 enable held", 64'(enable_ctl), 64'hC0);
        wr(4'd15, 8'h00);
        chk("R2 opts", 64'(serial_opts), 64'h5A);
        chk("R2 enable", 64'(enable_ctl), 64'h20);
        chk("R2 cfg", 64'(test_cfg), 64'h30);

        // R6 disabled write
        @(negedge clk);
        wr_addr = 4'd12; wr_data = 8'hFF; wr_en_n = 1'b1; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        wr(4'd15, 8'h00);
        chk("R6 opts unchanged", 64'(serial_opts), 64'h5A);

        // R7 held strobe, data changes under it
        @(negedge clk);
        wr_addr = 4'd14; wr_data = 8'h11; wr_en_n = 1'b0; wr_stb = 1'b1;
        @(negedge clk); wr_data = 8'h22;
        @(negedge clk); wr_data = 8'h33;
        @(negedge clk); wr_stb = 1'b0; wr_en_n = 1'b1;
        wr(4'd15, 8'h00);
        chk("R7 first data only", 64'(test_cfg), 64'h11);

        // R5 update pin latency
        wr(4'd0, 8'hAA);
        update_n = 1'b0;
        @(negedge clk);
        chk("R5 edge1 held", 64'(center_word[7:0]), 64'(pc[7:0]));
        @(negedge clk);
        chk("R5 edge2 held", 64'(center_word[7:0]), 64'(pc[7:0]));
        @(negedge clk);
        chk("R5 edge3 loaded", 64'(center_word[7:0]), 64'hAA);
        wr(4'd7, 8'h55);
        chk("R5 follow not yet", 64'(offset_word[15:8]), 64'(po[15:8]));
        @(negedge clk);
        chk("R5 follow", 64'(offset_word[15:8]), 64'h55);
        update_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset again, then R8 write at first edge after release
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 center reset", 64'(center_word), 64'h4000_0000_0000);
        chk("R1 enable reset", 64'(enable_ctl), 64'hC0);
        rst_n = 1'b1;
        wr_addr = 4'd13; wr_data = 8'h00; wr_en_n = 1'b0; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0; wr_en_n = 1'b1;
        wr(4'd15, 8'h00);
        chk("R8 enable kept", 64'(enable_ctl), 64'hC0);
        chk("R8 center kept", 64'(center_word), 64'h4000_0000_0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule